// File: doc/BRIEF.md
# Iterative Integer Multiplier with High-Half Result

This block multiplies two 64-bit integer operands over many clock cycles, using a one-bit-per-cycle shift-add loop. A 3-bit operation code selects one of five kinds of multiply:

- a 32-bit signed multiply whose result is sign-extended to 64 bits;
- a 64-bit signed multiply that keeps the low half of the product;
- a 64-bit unsigned multiply that returns the upper half of the 128-bit product.

Each of the two signed kinds has a plain form and a trapping form. The trapping form raises an overflow flag when the full product does not fit the destination width. The second operand comes either from a 64-bit operand port or from a short immediate.

The host raises `start` for one cycle while `busy` is low. The unit then iterates and pulses `done` for one cycle. On that cycle the new `result` and `ovf` appear, and they hold until the next completion.

Signed multiplies run on operand magnitudes. The 128-bit product is negated at the end when the operand signs differ.

Top module: `mulu_top`

## Requirements
- R1: A `start` seen at a rising edge while `busy` is low is accepted, and `busy` is high from the next cycle on. A `start` seen while `busy` is high is ignored, and it does not change the result of the operation in flight.
- R2: `done` is high for exactly one cycle, and it goes high 65 clock edges after the edge that accepted `start`. `busy` is low whenever `done` is high. A `start` seen in the `done` cycle is accepted.
- R3: For op codes 0 and 1, `result` is the low 32 bits of the signed product of the low 32 bits of each operand, sign-extended to 64 bits.
- R4: For op codes 2 and 3, `result` is the low 64 bits of the signed 64x64 product.
- R5: For op codes 4 to 7 (op bit 2 set), both operands are unsigned 64-bit values, and `result` is bits 127:64 of their 128-bit product.
- R6: For op code 1, `ovf` is 1 exactly when the signed 32x32 product lies outside [-2^31, 2^31-1].
- R7: For op code 3, `ovf` is 1 exactly when the signed 64x64 product lies outside [-2^63, 2^63-1].
- R8: For op codes 0, 2 and 4 to 7, `ovf` is 0 at completion.
- R9: When `imm_sel` is 1, the second operand is `imm` zero-extended to 64 bits, and `opnd_b` has no effect on the result. When `imm_sel` is 0, the second operand is `opnd_b`.
- R10: After reset, `result`, `ovf`, `done` and `busy` are 0. `result` and `ovf` change only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiply |
| op | input | 3 | Operation code (see R3 to R8) |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand, used when `imm_sel` is 0 |
| imm_sel | input | 1 | 1 selects the immediate as the second operand |
| imm | input | 8 | Immediate, zero-extended |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Result of the last completed operation |
| ovf | output | 1 | Overflow of the last completed trapping operation |

## Verification
The assertions take for granted that `start`, `op` and the operands are free of X after reset. They also assume the host reads `result` and `ovf` in the `done` cycle; nothing on the input side is constrained, because the block ignores requests while it is busy. The stimulus therefore drives every input to a defined value on falling edges. It deliberately raises `start` in the middle of an operation with different operands to exercise R1. It also starts operations in the `done` cycle and after idle gaps. Operand patterns cover the extreme signed values, products that sit exactly on the overflow boundary, all-ones unsigned operands, immediates with a garbage register operand, and pseudo-random values.

// File: rtl/mulu_pkg.sv
package mulu_pkg;

    typedef enum logic [2:0] {
        OP_MUL32      = 3'd0,
        OP_MUL32_TRAP = 3'd1,
        OP_MUL64      = 3'd2,
        OP_MUL64_TRAP = 3'd3,
        OP_MULHU      = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

    function automatic logic op_is_high(input logic [2:0] op);
        return op[2];
    endfunction

    function automatic logic op_is_long(input logic [2:0] op);
        return (op[2:1] == 2'b00);
    endfunction

    function automatic logic op_traps(input logic [2:0] op);
        return !op[2] && op[0];
    endfunction

endpackage

// File: rtl/mulu_prep.sv
module mulu_prep
    import mulu_pkg::*;
#(
    parameter int W  = 64,
    parameter int IW = 8
) (
    input  logic [2:0]    op,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic          imm_sel,
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  mag_a,
    output logic [W-1:0]  mag_b,
    output logic          neg
);
    localparam int HW = W / 2;

    logic [W-1:0] b_src;
    logic [W-1:0] sa;
    logic [W-1:0] sb;

    always_comb begin
        b_src = imm_sel ? W'(imm) : opnd_b;
        if (op_is_long(op)) begin
            sa = {{HW{opnd_a[HW-1]}}, opnd_a[HW-1:0]};
            sb = {{HW{b_src[HW-1]}}, b_src[HW-1:0]};
        end else begin
            sa = opnd_a;
            sb = b_src;
        end
        if (op_is_high(op)) begin
            mag_a = opnd_a;
            mag_b = b_src;
            neg   = 1'b0;
        end else begin
            mag_a = sa[W-1] ? (~sa + 1'b1) : sa;
            mag_b = sb[W-1] ? (~sb + 1'b1) : sb;
            neg   = sa[W-1] ^ sb[W-1];
        end
    end
endmodule

// File: rtl/mulu_core.sv
module mulu_core
    import mulu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     op_i,
    input  logic [W-1:0]   mag_a,
    input  logic [W-1:0]   mag_b,
    input  logic           neg_i,
    output logic           busy,
    output logic           fin,
    output logic [2*W-1:0] prod,
    output logic [2:0]     op_o,
    output logic           neg_o
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
        logic [W-1:0]  mc;
        logic [2:0]    op;
        logic          neg;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.hi} + (st_q.lo[0] ? {1'b0, st_q.mc} : '0);
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                    st_d.hi    = '0;
                    st_d.lo    = mag_b;
                    st_d.mc    = mag_a;
                    st_d.op    = op_i;
                    st_d.neg   = neg_i;
                end
            end
            PH_RUN: begin
                st_d.hi  = sum[W:1];
                st_d.lo  = {sum[0], st_q.lo[W-1:1]};
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CW'(W - 1)) st_d.phase = PH_FIN;
            end
            PH_FIN:  st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign busy  = (st_q.phase != PH_IDLE);
    assign fin   = (st_q.phase == PH_FIN);
    assign prod  = {st_q.hi, st_q.lo};
    assign op_o  = st_q.op;
    assign neg_o = st_q.neg;
endmodule

// File: rtl/mulu_fin.sv
module mulu_fin
    import mulu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [2:0]     op,
    input  logic           neg,
    input  logic [2*W-1:0] prod,
    output logic [W-1:0]   res,
    output logic           ovf
);
    localparam int HW = W / 2;

    logic [2*W-1:0] sp;

    always_comb begin
        sp = neg ? (~prod + 1'b1) : prod;
        if (op_is_high(op)) begin
            res = prod[2*W-1:W];
            ovf = 1'b0;
        end else if (op_is_long(op)) begin
            res = {{HW{sp[HW-1]}}, sp[HW-1:0]};
            ovf = op_traps(op) && (sp[2*W-1:HW-1] != {(W+HW+1){sp[HW-1]}});
        end else begin
            res = sp[W-1:0];
            ovf = op_traps(op) && (sp[2*W-1:W-1] != {(W+1){sp[W-1]}});
        end
    end
endmodule

// File: rtl/mulu_top.sv
module mulu_top
    import mulu_pkg::*;
#(
    parameter int W  = 64,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic          imm_sel,
    input  logic [IW-1:0] imm,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  result,
    output logic          ovf
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         ovf;
        logic         done;
        logic [2:0]   op;
    } out_st_t;

    logic [W-1:0]   mag_a, mag_b;
    logic           neg_in, neg_run;
    logic           core_busy, core_fin;
    logic [2*W-1:0] prod;
    logic [2:0]     run_op;
    logic [W-1:0]   fin_res;
    logic           fin_ovf;
    logic [2:0]     done_op;

    out_st_t out_d, out_q;

    mulu_prep #(.W(W), .IW(IW)) u_prep (
        .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_sel(imm_sel), .imm(imm),
        .mag_a(mag_a), .mag_b(mag_b), .neg(neg_in)
    );

    mulu_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .op_i(op),
        .mag_a(mag_a), .mag_b(mag_b), .neg_i(neg_in),
        .busy(core_busy), .fin(core_fin), .prod(prod), .op_o(run_op), .neg_o(neg_run)
    );

    mulu_fin #(.W(W)) u_fin (
        .op(run_op), .neg(neg_run), .prod(prod), .res(fin_res), .ovf(fin_ovf)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = core_fin;
        if (core_fin) begin
            out_d.res = fin_res;
            out_d.ovf = fin_ovf;
            out_d.op  = run_op;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign busy    = core_busy;
    assign done    = out_q.done;
    assign result  = out_q.res;
    assign ovf     = out_q.ovf;
    assign done_op = out_q.op;
endmodule

// File: rtl/mulu_chk.sv
module mulu_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         ovf,
    input logic [W-1:0] result,
    input logic [2:0]   done_op
);
    localparam int HW = W / 2;

    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r3_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_op[2:1] == 2'b00) |-> (result[W-1:HW-1] == {(HW+1){result[HW-1]}}));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (done_op[2] || !done_op[0])) |-> !ovf);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(ovf)));
endmodule

bind mulu_top mulu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ovf(ovf), .result(result), .done_op(done_op)
);

// File: tb/test_mulu_top.sv
`timescale 1ns/1ps
module test_mulu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        imm_sel = 1'b0;
    logic [7:0]  imm = '0;
    logic        busy, done, ovf;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit sim_end = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    mulu_top i_mulu_top (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .imm_sel(imm_sel), .imm(imm),
        .busy(busy), .done(done), .result(result), .ovf(ovf)
    );

    function automatic logic [63:0] xs(input logic [63:0] x);
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic ref_mul(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] r, output logic v);
        logic        [127:0] up;
        logic signed [127:0] sa, sb, ps;
        if (o[2]) begin
            up = {64'b0, a} * {64'b0, b};
            r = up[127:64];
            v = 1'b0;
        end else if (o[1]) begin
            sa = $signed(a);
            sb = $signed(b);
            ps = sa * sb;
            r = ps[63:0];
            v = o[0] && ((ps > 128'sh7FFF_FFFF_FFFF_FFFF) || (ps < -128'sh8000_0000_0000_0000));
        end else begin
            sa = $signed(a[31:0]);
            sb = $signed(b[31:0]);
            ps = sa * sb;
            r = {{32{ps[31]}}, ps[31:0]};
            v = o[0] && ((ps > 128'sh7FFF_FFFF) || (ps < -128'sh8000_0000));
        end
    endtask

    // behavioural model: countdown to completion
    int          m_cnt = 0;
    logic        m_done = 0, m_ovf = 0, p_ovf = 0;
    logic [63:0] m_res = '0, p_res = '0;
    string       m_tag = "R10", m_otag = "R10", p_tag = "", p_otag = "";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_res = '0; m_ovf = 0;
        end else begin
            automatic bit was_busy = (m_cnt != 0);
            automatic logic [63:0] bsel;
            m_done = 0;
            if (m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1; m_res = p_res; m_ovf = p_ovf; m_tag = p_tag; m_otag = p_otag;
                end
            end
            if (start && !was_busy) begin
                bsel = imm_sel ? {56'b0, imm} : opnd_b;
                ref_mul(op, opnd_a, bsel, p_res, p_ovf);
                p_tag  = imm_sel ? "R9" : (op[2] ? "R5" : (op[1] ? "R4" : "R3"));
                p_otag = (op[2] || !op[0]) ? "R8" : (op[1] ? "R7" : "R6");
                m_cnt = 65;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !sim_end) begin
            chk(busy == (m_cnt != 0), "R1", "busy", 64'(busy), 64'(m_cnt != 0));
            chk(done == m_done, "R2", "done", 64'(done), 64'(m_done));
            chk(result == m_res, m_done ? m_tag : "R10", "result", result, m_res);
            chk(ovf == m_ovf, m_done ? m_otag : "R10", "ovf", 64'(ovf), 64'(m_ovf));
        end
    end

    // drive at current negedge; return at the negedge where done is visible (plus gap)
    task automatic run_op(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                          input bit isel, input logic [7:0] im, input bit intrude, input int gap);
        start = 1; op = o; opnd_a = a; opnd_b = b; imm_sel = isel; imm = im;
        @(negedge clk);
        start = 0; opnd_a = ~a; opnd_b = xs(b ^ 64'h55); imm = ~im; imm_sel = ~isel;
        if (intrude) begin
            repeat (10) @(negedge clk);
            start = 1; op = ~o; opnd_a = 64'h7; opnd_b = 64'h3; // R1: must be ignored
            @(negedge clk);
            start = 0;
            repeat (54) @(negedge clk);
        end else begin
            repeat (65) @(negedge clk);
        end
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog expired act=%h exp=%h", 64'(0), 64'(1));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(result == 0, "R10", "reset result", result, 0);
        chk(ovf == 0 && done == 0, "R10", "reset ovf/done", {62'b0, ovf, done}, 0);
        chk(busy == 0, "R10", "reset busy", 64'(busy), 0);
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R3/R6 longword boundaries
        run_op(3'd1, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000, 0, 0, 0, 0); // 2^31 ovf
        run_op(3'd1, 64'h0000_0000_0001_0000, 64'hFFFF_FFFF_FFFF_8000, 0, 0, 0, 2); // -2^31 ok
        run_op(3'd1, 64'h1234_5678_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0); // R6 ovf
        run_op(3'd0, 64'h0000_0000_8000_0000, 64'hABCD_0000_FFFF_FFFF, 0, 0, 0, 0); // R8 no ovf
        run_op(3'd0, 64'h0000_0000_0000_0005, 64'h0000_0000_FFFF_FFFD, 0, 0, 1, 0); // R1 intrude
        // R4/R7 quadword boundaries
        run_op(3'd3, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0); // ovf
        run_op(3'd3, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 0, 0, 0, 1); // exact min
        run_op(3'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
        run_op(3'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, 0); // R8
        run_op(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, 0);
        run_op(3'd2, 64'h0, 64'h1234, 0, 0, 0, 3);
        // R5 high half
        run_op(3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
        run_op(3'd7, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0002, 0, 0, 0, 0);
        run_op(3'd5, 64'hDEAD_BEEF_0BAD_F00D, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
        // R9 immediate with garbage register operand
        run_op(3'd3, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFF, 1, 8'hFF, 0, 0);
        run_op(3'd1, 64'h0100_0000_0100_0000, 64'h0000_0000_0000_0000, 1, 8'h80, 0, 0);
        run_op(3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, 8'h10, 0, 0);

        for (int i = 0; i < 40; i++) begin
            logic [63:0] a, b;
            seed = xs(seed); a = seed;
            seed = xs(seed); b = seed;
            if (seed[9]) a = a >> seed[15:10];
            if (seed[17]) b = {{32{b[40]}}, b[31:0]} >> seed[22:18];
            run_op(seed[2:0], a, b, seed[5] & seed[6], seed[33:26], seed[7] & seed[8], int'(seed[4:3]));
        end

        repeat (3) @(negedge clk);
        sim_end = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule